// File: doc/BRIEF.md
# Shift and Rotate Unit

This block executes the shift and rotate group of a 32-bit integer core. From one instruction word it works out the operation kind, the direction, the operand width and the shift count. It then returns the shifted operand, the five condition flags (extend X, negative N, zero Z, overflow V, carry C) and the number of execution clocks the bus sequencer must allow. The kinds are arithmetic shift, logical shift, plain rotate and rotate through the extend bit. Each works on byte, word or long operands, and there is also a one-position word form used for memory operands.

The count comes from one of two places. It is either a 3-bit immediate field, where 0 stands for 8, or the low six bits of a data register chosen by the same field. The unit drives that register index on a read-port select and takes the value back in the same cycle. Execution time grows by a fixed number of clocks per position shifted. A single `start` pulse registers the whole result, and `done` marks the cycle in which it is valid. Fetching the operand and writing it back are handled elsewhere.

Top module: `shift_rotate_unit`

## Requirements
- R1: While `rst_n` is low at a clock edge, `done`, `result`, all five flags and `cycles` are cleared to 0 at that edge.
- R2: A `start` sampled high at an edge makes `done` high after that edge with the result of that request. `done` is low after any edge at which `start` is low.
- R3: Instruction bits 11:9 always drive `rd_sel`. If bit 5 is 1, the count is `rd_data` modulo 64. If bit 5 is 0, the count is the value of bits 11:9, and 0 there means 8.
- R4: `cycles` equals BASE_CYCLES (6) plus CYCLES_PER_POS (2) times the count. A count of 0 gives 6.
- R5: Bits 7:6 = 11 select the memory form: a word operation by exactly one position, with the kind in bits 10:9, and `cycles` = 8. Otherwise bits 7:6 give the width (00 byte, 01 word, 10 long) and bits 4:3 give the kind: 00 arithmetic shift, 01 logical shift, 10 rotate through X, 11 plain rotate. Bit 8 = 1 means left.
- R6: Logical shifts fill the vacated bits with 0. C and X take the last bit shifted out. Counts at or beyond the width give a zero result. V is 0.
- R7: Arithmetic right shift fills the vacated high bits with the original sign bit. C and X take the last bit out, and a count beyond the width gives the sign bit. V is 0.
- R8: Arithmetic left shift sets V when the operand's sign bit takes more than one value at any point during the shift. C and X take the last bit out.
- R9: A plain rotate clears V and leaves X unchanged. C is the last bit carried round: the result's LSB for a left rotate, its MSB for a right rotate.
- R10: A rotate through X treats X and the operand as a ring of width+1 bits. The bit leaving the operand goes to X and C, and the old X enters the vacated end.
- R11: N is the result's top bit at the operand width, and Z is set when the result is 0 at that width. `result` bits above the width equal the corresponding `operand` bits.
- R12: With a count of 0, `result` equals `operand`, C and V are 0, X is unchanged, and N and Z follow the operand.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Request strobe; all inputs are sampled on this edge |
| instr | input | 16 | Instruction word |
| operand | input | 32 | Value to shift |
| x_in | input | 1 | Current extend flag |
| rd_sel | output | 3 | Data register read-port index |
| rd_data | input | 32 | Data register read-port value |
| done | output | 1 | Result valid |
| result | output | 32 | Shifted value |
| x_out | output | 1 | New extend flag |
| n_out | output | 1 | New negative flag |
| z_out | output | 1 | New zero flag |
| v_out | output | 1 | New overflow flag |
| c_out | output | 1 | New carry flag |
| cycles | output | 8 | Execution clocks for the sequencer |

## Verification
Two paths can meet in one request: the register-count path and the zero-count path. A register value that is a multiple of 64, such as 64 or 128, reduces to a zero count. The bench loads such a value into the register file and issues a rotate through X with a register count. The result must then equal the operand, with C cleared, X held and `cycles` at the base value. The same register holding 70 must instead behave as a count of 6, which shows that the modulo is applied before the zero test.

// File: rtl/shr_pkg.sv
// Package: shared kinds, widths and the instruction-field decode
// for the shift and rotate unit.
package shr_pkg;

    typedef enum logic [1:0] {
        SK_ARITH = 2'b00,
        SK_LOGIC = 2'b01,
        SK_ROTX  = 2'b10,
        SK_ROT   = 2'b11
    } shr_kind_e;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_WORD = 2'b01,
        SZ_LONG = 2'b10,
        SZ_MEM  = 2'b11
    } shr_size_e;

    localparam int SHR_DATA_W = 32;
    localparam int SHR_INSTR_W = 16;
    localparam int SHR_SEL_W = 3;

    // Kind field: bits 10:9 in the memory form, bits 4:3 otherwise.
    function automatic shr_kind_e decode_kind(input logic [SHR_INSTR_W-1:0] iw);
        if (iw[7:6] == 2'b11)
            return shr_kind_e'(iw[10:9]);
        return shr_kind_e'(iw[4:3]);
    endfunction

endpackage

// File: rtl/shr_count_sel.sv
// Module: shr_count_sel
// Decodes width, kind, direction and effective shift count from the
// instruction word. Drives the register read-port select and expects
// rd_data to answer combinationally in the same cycle. The count is
// reduced modulo 2**CNT_W.
module shr_count_sel
    import shr_pkg::*;
#(
    parameter int CNT_W = 6
) (
    input  logic [SHR_INSTR_W-1:0] instr,
    input  logic [SHR_DATA_W-1:0]  rd_data,
    output logic [SHR_SEL_W-1:0]   rd_sel,
    output shr_size_e              size,
    output shr_kind_e              kind,
    output logic                   left,
    output logic                   memform,
    output logic [CNT_W-1:0]       count
);
    logic [SHR_SEL_W-1:0] field;

    // Field extraction and basic decode.
    always_comb begin
        field   = instr[11:9];
        rd_sel  = field;
        size    = shr_size_e'(instr[7:6]);
        memform = (instr[7:6] == 2'b11);
        kind    = decode_kind(instr);
        left    = instr[8];
    end

    // Count selection: memory form, register modulo 2**CNT_W, or immediate with 0 meaning 8.
    always_comb begin
        if (memform)
            count = CNT_W'(1);
        else if (instr[5])
            count = rd_data[CNT_W-1:0];
        else if (field == '0)
            count = CNT_W'(8);
        else
            count = CNT_W'(field);
    end
endmodule

// File: rtl/shr_lane.sv
// Module: shr_lane
// Combinational shift/rotate of one fixed operand width W. Uses
// closed-form shifts on a 64-bit extension, so 2**CNT_W must not
// exceed 64. With a zero count, the operand passes through with
// C and V cleared and X kept.
module shr_lane
    import shr_pkg::*;
#(
    parameter int W     = 8,
    parameter int CNT_W = 6
) (
    input  logic [W-1:0]     op,
    input  logic [CNT_W-1:0] cnt,
    input  shr_kind_e        kind,
    input  logic             left,
    input  logic             x_in,
    output logic [W-1:0]     res,
    output logic             x_out,
    output logic             c_out,
    output logic             v_out
);
    localparam int EW = 64;
    localparam int IW = 7;
    localparam int RW = W + 1;

    logic [EW-1:0]   zx, sx, top, sra, shl, shr, ring_e;
    logic [EW-1:0]   win_mask, win;
    logic [2*EW-1:0] dbl_p, dbl_e, rot_p, rot_e;
    logic [IW-1:0]   c7;
    logic [CNT_W-1:0] r_p, r_e;
    logic [5:0]      idx_l, idx_r;

    // Extensions, shifted copies and the overflow window.
    always_comb begin
        zx       = EW'(op);
        sx       = EW'($signed(op));
        top      = {op, {(EW-W){1'b0}}};
        c7       = IW'(cnt);
        shl      = zx << cnt;
        shr      = zx >> cnt;
        sra      = $signed(sx) >>> cnt;
        win_mask = ~({EW{1'b1}} >> (c7 + IW'(1)));
        win      = top & win_mask;
        idx_l    = 6'(IW'(64) - c7);
        idx_r    = 6'(c7 - IW'(1));
    end

    // Rotation by doubled ring: plain (W bits) and through X (W+1 bits).
    always_comb begin
        r_p    = CNT_W'(int'(cnt) % W);
        r_e    = CNT_W'(int'(cnt) % RW);
        ring_e = zx | (EW'(x_in) << W);
        dbl_p  = ({{EW{1'b0}}, zx} << W) | {{EW{1'b0}}, zx};
        dbl_e  = ({{EW{1'b0}}, ring_e} << RW) | {{EW{1'b0}}, ring_e};
        rot_p  = left ? (dbl_p >> (W - int'(r_p)))  : (dbl_p >> r_p);
        rot_e  = left ? (dbl_e >> (RW - int'(r_e))) : (dbl_e >> r_e);
    end

    // Result and flag selection per kind.
    always_comb begin
        res   = op;
        x_out = x_in;
        c_out = 1'b0;
        v_out = 1'b0;
        if (cnt != '0) begin
            unique case (kind)
                SK_ARITH: begin
                    if (left) begin
                        res   = shl[W-1:0];
                        c_out = top[idx_l];
                        v_out = (win != '0) && (win != win_mask);
                    end else begin
                        res   = sra[W-1:0];
                        c_out = sx[idx_r];
                    end
                    x_out = c_out;
                end
                SK_LOGIC: begin
                    if (left) begin
                        res   = shl[W-1:0];
                        c_out = top[idx_l];
                    end else begin
                        res   = shr[W-1:0];
                        c_out = zx[idx_r];
                    end
                    x_out = c_out;
                end
                SK_ROTX: begin
                    res   = rot_e[W-1:0];
                    c_out = rot_e[W];
                    x_out = rot_e[W];
                end
                SK_ROT: begin
                    res   = rot_p[W-1:0];
                    c_out = left ? rot_p[0] : rot_p[W-1];
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/shr_datapath.sv
// Module: shr_datapath
// Instantiates one lane per operand width (8, 16, 32) and selects
// the lane for the decoded size. The memory form uses the word lane.
// Produces the full 32-bit result, with the bits above the width
// taken from the operand, plus N and Z at the operand width.
module shr_datapath
    import shr_pkg::*;
#(
    parameter int CNT_W  = 6,
    parameter int LANES  = 3
) (
    input  logic [SHR_DATA_W-1:0] operand,
    input  logic [CNT_W-1:0]      count,
    input  shr_size_e             size,
    input  shr_kind_e             kind,
    input  logic                  left,
    input  logic                  x_in,
    output logic [SHR_DATA_W-1:0] result,
    output logic                  x_out,
    output logic                  n_out,
    output logic                  z_out,
    output logic                  v_out,
    output logic                  c_out
);
    localparam int SEL_W = $clog2(LANES);

    logic [SHR_DATA_W-1:0] l_res  [LANES];
    logic [SHR_DATA_W-1:0] l_mask [LANES];
    logic                  l_x [LANES];
    logic                  l_c [LANES];
    logic                  l_v [LANES];
    logic                  l_n [LANES];
    logic [SEL_W-1:0]      sel;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        localparam int LW = 8 << g;
        logic [LW-1:0] lr;
        shr_lane #(.W(LW), .CNT_W(CNT_W)) u_lane (
            .op    (operand[LW-1:0]),
            .cnt   (count),
            .kind  (kind),
            .left  (left),
            .x_in  (x_in),
            .res   (lr),
            .x_out (l_x[g]),
            .c_out (l_c[g]),
            .v_out (l_v[g])
        );
        assign l_res[g]  = SHR_DATA_W'(lr);
        assign l_mask[g] = SHR_DATA_W'({LW{1'b1}});
        assign l_n[g]    = lr[LW-1];
    end

    // Lane selection from the size field.
    always_comb begin
        unique case (size)
            SZ_BYTE: sel = SEL_W'(0);
            SZ_LONG: sel = SEL_W'(2);
            default: sel = SEL_W'(1);
        endcase
    end

    // Merge the selected lane with untouched upper operand bits.
    always_comb begin
        result = (l_res[sel] & l_mask[sel]) | (operand & ~l_mask[sel]);
        x_out  = l_x[sel];
        c_out  = l_c[sel];
        v_out  = l_v[sel];
        n_out  = l_n[sel];
        z_out  = (l_res[sel] & l_mask[sel]) == '0;
    end
endmodule

// File: rtl/shift_rotate_unit.sv
// Module: shift_rotate_unit
// Top of the shift and rotate unit. Decodes the count, runs the
// width lanes and registers the result, flags and execution cycle
// count on each start pulse. Assumes rd_data answers rd_sel within
// the same cycle. Reset is synchronous and active low.
module shift_rotate_unit
    import shr_pkg::*;
#(
    parameter int CNT_W          = 6,
    parameter int CYC_W          = 8,
    parameter int BASE_CYCLES    = 6,
    parameter int CYCLES_PER_POS = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start,
    input  logic [15:0]           instr,
    input  logic [31:0]           operand,
    input  logic                  x_in,
    output logic [2:0]            rd_sel,
    input  logic [31:0]           rd_data,
    output logic                  done,
    output logic [31:0]           result,
    output logic                  x_out,
    output logic                  n_out,
    output logic                  z_out,
    output logic                  v_out,
    output logic                  c_out,
    output logic [CYC_W-1:0]      cycles
);
    localparam int MAX_CNT = (1 << CNT_W) - 1;
    localparam int MEM_CYC = BASE_CYCLES + CYCLES_PER_POS;

    shr_size_e        size;
    shr_kind_e        kind;
    logic             left, memform;
    logic [CNT_W-1:0] count;
    logic [31:0]      d_res;
    logic             d_x, d_n, d_z, d_v, d_c;
    logic [CYC_W-1:0] d_cyc;

    shr_count_sel #(.CNT_W(CNT_W)) u_cnt (
        .instr   (instr),
        .rd_data (rd_data),
        .rd_sel  (rd_sel),
        .size    (size),
        .kind    (kind),
        .left    (left),
        .memform (memform),
        .count   (count)
    );

    shr_datapath #(.CNT_W(CNT_W), .LANES(3)) u_dp (
        .operand (operand),
        .count   (count),
        .size    (size),
        .kind    (kind),
        .left    (left),
        .x_in    (x_in),
        .result  (d_res),
        .x_out   (d_x),
        .n_out   (d_n),
        .z_out   (d_z),
        .v_out   (d_v),
        .c_out   (d_c)
    );

    // Execution time: base plus a fixed cost per position.
    always_comb begin
        d_cyc = CYC_W'(BASE_CYCLES + CYCLES_PER_POS * int'(count));
    end

    // Output register, loaded on start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done   <= 1'b0;
            result <= '0;
            x_out  <= 1'b0;
            n_out  <= 1'b0;
            z_out  <= 1'b0;
            v_out  <= 1'b0;
            c_out  <= 1'b0;
            cycles <= '0;
        end else begin
            done <= start;
            if (start) begin
                result <= d_res;
                x_out  <= d_x;
                n_out  <= d_n;
                z_out  <= d_z;
                v_out  <= d_v;
                c_out  <= d_c;
                cycles <= d_cyc;
            end
        end
    end

    initial begin
        assert (BASE_CYCLES + CYCLES_PER_POS * MAX_CNT < (1 << CYC_W))
            else $error("cycle width too small");
        assert (CNT_W <= 6) else $error("count width too large for lanes");
    end

    // R2: done follows start by one edge.
    p_done_follow_r2: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> done);
    p_done_drop_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> !done);
    // R12: zero count leaves C, V clear and X held.
    p_zero_cnt_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (start && count == '0) |=> (!c_out && !v_out && x_out == $past(x_in)
                                    && result == $past(operand)));
    // R9: plain rotate keeps X and clears V.
    p_rot_keep_x_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (start && kind == SK_ROT) |=> (x_out == $past(x_in) && !v_out));
    // R5: memory form always takes one position.
    p_mem_cycles_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (start && memform) |=> (cycles == CYC_W'(MEM_CYC)));
    // R11: byte operations leave the upper bits of the operand.
    p_upper_kept_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (start && size == SZ_BYTE) |=> (result[31:8] == $past(operand[31:8])));
endmodule

// File: tb/tb_shift_rotate_unit.sv
module tb_shift_rotate_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [15:0] instr = '0;
    logic [31:0] operand = '0;
    logic        x_in = 1'b0;
    logic [2:0]  rd_sel;
    logic [31:0] rd_data;
    logic        done;
    logic [31:0] result;
    logic        x_out, n_out, z_out, v_out, c_out;
    logic [7:0]  cycles;
    logic [31:0] rf [8];
    int n_tests = 0;
    int n_fail = 0;
    bit finished = 0;

    always #5 clk = ~clk;
    assign rd_data = rf[rd_sel];

    shift_rotate_unit dut (
        .clk(clk), .rst_n(rst_n), .start(start), .instr(instr),
        .operand(operand), .x_in(x_in), .rd_sel(rd_sel), .rd_data(rd_data),
        .done(done), .result(result), .x_out(x_out), .n_out(n_out),
        .z_out(z_out), .v_out(v_out), .c_out(c_out), .cycles(cycles)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Register-form instruction: dir, kind, size, count-from-register flag, field.
    function automatic logic [15:0] mk(input logic dir, input logic [1:0] kind,
                                       input logic [1:0] sz, input logic ir,
                                       input logic [2:0] fld);
        return {4'he, fld, dir, sz, ir, kind, 3'b000};
    endfunction

    function automatic logic [15:0] mk_mem(input logic dir, input logic [1:0] kind);
        return {4'he, 1'b0, kind, dir, 2'b11, 6'b0};
    endfunction

    // Reference model: one position at a time.
    task automatic model(input logic [15:0] iw, input logic [31:0] op, input logic xi,
                         output logic [31:0] r, output logic xo, no, zo, vo, co,
                         output int cyc);
        bit mem = (iw[7:6] == 2'b11);
        int w = mem ? 16 : (8 << iw[7:6]);
        logic [1:0] k = mem ? iw[10:9] : iw[4:3];
        bit lf = iw[8];
        int cnt;
        logic [31:0] m = (w == 32) ? 32'hffff_ffff : ((32'd1 << w) - 1);
        logic [31:0] v = op & m;
        logic msb, lsb;
        if (mem) cnt = 1;
        else if (iw[5]) cnt = int'(rf[iw[11:9]] % 64);
        else cnt = (iw[11:9] == 0) ? 8 : int'(iw[11:9]);
        xo = xi; co = 0; vo = 0;
        for (int i = 0; i < cnt; i++) begin
            msb = v[w-1]; lsb = v[0];
            case (k)
                2'd0: begin
                    if (lf) begin v = (v << 1) & m; if (v[w-1] != msb) vo = 1; co = msb; end
                    else begin v = (v >> 1) | ({31'b0, msb} << (w-1)); co = lsb; end
                    xo = co;
                end
                2'd1: begin
                    if (lf) begin v = (v << 1) & m; co = msb; end
                    else begin v = v >> 1; co = lsb; end
                    xo = co;
                end
                2'd2: begin
                    if (lf) begin v = ((v << 1) & m) | {31'b0, xo}; co = msb; end
                    else begin v = (v >> 1) | ({31'b0, xo} << (w-1)); co = lsb; end
                    xo = co;
                end
                default: begin
                    if (lf) begin v = ((v << 1) & m) | {31'b0, msb}; co = msb; end
                    else begin v = (v >> 1) | ({31'b0, lsb} << (w-1)); co = lsb; end
                end
            endcase
        end
        r = (op & ~m) | v;
        no = v[w-1];
        zo = (v == 0);
        cyc = 6 + 2 * cnt;
    endtask

    // Issue one request and compare every output against the model.
    task automatic run(input string tag, input logic [15:0] iw, input logic [31:0] op,
                       input logic xi);
        logic [31:0] er; logic ex, en, ez, ev, ec; int ecyc;
        model(iw, op, xi, er, ex, en, ez, ev, ec, ecyc);
        @(negedge clk);
        instr = iw; operand = op; x_in = xi; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk({tag, " done R2"}, {31'b0, done}, 32'd1);
        chk({tag, " result"}, result, er);
        chk({tag, " flags XNZVC R11"}, {27'b0, x_out, n_out, z_out, v_out, c_out},
            {27'b0, ex, en, ez, ev, ec});
        chk({tag, " cycles R4"}, {24'b0, cycles}, 32'(ecyc));
    endtask

    task automatic t_reset();
        chk("R1 done", {31'b0, done}, 0);
        chk("R1 result", result, 0);
        chk("R1 flags", {27'b0, x_out, n_out, z_out, v_out, c_out}, 0);
        chk("R1 cycles", {24'b0, cycles}, 0);
    endtask

    task automatic t_logical();
        run("R6 lsl byte 3", mk(1, 2'd1, 2'd0, 0, 3'd3), 32'h1234_56b1, 0);
        chk("R6 lsl byte hand", result, 32'h1234_5688);
        run("R6 lsr long 5", mk(0, 2'd1, 2'd2, 0, 3'd5), 32'h8000_0031, 1);
        rf[2] = 32'd40;
        run("R6 lsl long reg 40", mk(1, 2'd1, 2'd2, 1, 3'd2), 32'hffff_ffff, 0);
        chk("R6 beyond width zero", result, 32'h0);
        rf[3] = 32'd16;
        run("R6 lsr word exact 16", mk(0, 2'd1, 2'd1, 1, 3'd3), 32'h0000_8000, 0);
    endtask

    task automatic t_arith();
        run("R7 asr byte 2", mk(0, 2'd0, 2'd0, 0, 3'd2), 32'h0000_0082, 0);
        chk("R7 asr sign fill", result, 32'h0000_00e0);
        rf[4] = 32'd50;
        run("R7 asr word 50", mk(0, 2'd0, 2'd1, 1, 3'd4), 32'h0000_9000, 0);
        run("R8 asl byte overflow", mk(1, 2'd0, 2'd0, 0, 3'd2), 32'h0000_0030, 0);
        chk("R8 v set", {31'b0, v_out}, 1);
        run("R8 asl no overflow", mk(1, 2'd0, 2'd0, 0, 3'd2), 32'h0000_00f0, 0);
        chk("R8 v clear", {31'b0, v_out}, 0);
        run("R8 asl long 1", mk(1, 2'd0, 2'd2, 0, 3'd1), 32'h4000_0001, 1);
    endtask

    task automatic t_rotate();
        run("R9 rol word 4", mk(1, 2'd3, 2'd1, 0, 3'd4), 32'hcafe_1234, 1);
        chk("R9 rol hand", result, 32'hcafe_2341);
        run("R9 ror long 0->8", mk(0, 2'd3, 2'd2, 0, 3'd0), 32'h0000_0080, 0);
        chk("R3 imm zero is 8 cycles", {24'b0, cycles}, 32'd22);
        run("R9 rol byte 8 full", mk(1, 2'd3, 2'd0, 0, 3'd0), 32'h0000_0001, 0);
        run("R10 roxl byte 1", mk(1, 2'd2, 2'd0, 0, 3'd1), 32'h0000_0080, 1);
        chk("R10 roxl hand", result, 32'h0000_0001);
        rf[5] = 32'd33;
        run("R10 roxr long 33", mk(0, 2'd2, 2'd2, 1, 3'd5), 32'h1234_5678, 1);
        run("R10 roxr word 7", mk(0, 2'd2, 2'd1, 0, 3'd7), 32'h0000_00ff, 0);
    endtask

    task automatic t_mem();
        run("R5 mem asl", mk_mem(1, 2'd0), 32'hdead_4000, 0);
        run("R5 mem roxr", mk_mem(0, 2'd2), 32'h0000_0001, 1);
        run("R5 mem ror", mk_mem(0, 2'd3), 32'h0000_0001, 0);
        chk("R5 mem cycles", {24'b0, cycles}, 32'd8);
    endtask

    task automatic t_regcount();
        rf[6] = 32'd70;
        @(negedge clk);
        instr = mk(1, 2'd1, 2'd2, 1, 3'd6);
        #1 chk("R3 rd_sel", {29'b0, rd_sel}, 32'd6);
        run("R3 reg 70 mod 64", mk(1, 2'd1, 2'd2, 1, 3'd6), 32'h0000_0003, 0);
        chk("R3 count six", {24'b0, cycles}, 32'd18);
        rf[6] = 32'd128;
        run("R12 roxl reg zero", mk(1, 2'd2, 2'd0, 1, 3'd6), 32'h0000_0080, 1);
        chk("R12 passthrough", result, 32'h0000_0080);
        chk("R12 c clear x held", {30'b0, c_out, x_out}, 32'd1);
        run("R12 lsr zero count", mk(0, 2'd1, 2'd2, 1, 3'd6), 32'h0000_0000, 1);
    endtask

    task automatic t_pulse();
        @(negedge clk);
        chk("R2 done low after idle edge", {31'b0, done}, 0);
    endtask

    initial begin
        for (int i = 0; i < 8; i++) rf[i] = 32'd0;
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_logical();
        t_arith();
        t_rotate();
        t_mem();
        t_regcount();
        t_pulse();
        if (!finished) begin
            finished = 1;
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        #200000;
        if (!finished) begin
            finished = 1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule